// File: doc/BRIEF.md
# Dual-Rate LED Blink and Dimming Engine

This block drives eight open-drain LED outputs from two shared blink/PWM generators. Each generator has an 8-bit prescale value that sets its period and an 8-bit duty value that sets how long the LED is lit in each period. A fixed 152 Hz base rate is derived from the system clock. A first divider produces a step tick at 256 x 152 Hz. Each generator advances its 8-bit phase counter once every (prescale + 1) step ticks, so one PWM period is 256 phase steps and lasts (prescale + 1) / 152 s.

Each LED picks one of four sources through a 2-bit selector code: released, held on, generator 0 or generator 1. The prescale, duty and selector values come straight from an external register file. A prescale or duty change is latched only at the generator's period boundary, so a period is never cut short or stretched. Each output is an output-enable: 1 means the driver pulls the pin low and the LED is lit; 0 means the pin is released and the LED is dark.

Top module: `led_blink_engine`

## Requirements
- R1: With step divider D, a generator with prescale P has a PWM period of exactly 256 x (P + 1) x D clock cycles, measured from one rising edge of a following output to the next.
- R2: Within each period, a following output is 1 for exactly duty x (P + 1) x D cycles. Duty 0 never turns it on. Duty 255 leaves it off for exactly one phase step per period.
- R3: Selector code 00 forces the output to 0 (released, LED off). Code 01 forces it to 1 (pulled low, LED on).
- R4: Selector code 10 follows generator 0 and code 11 follows generator 1. The two generators run with independent prescale and duty values.
- R5: LED0 to LED3 take their codes from sel_lo_i and LED4 to LED7 from sel_hi_i. LEDn uses bits [2(n mod 4)+1 : 2(n mod 4)] of its selector byte.
- R6: A new prescale or duty value takes effect only when the generator's phase wraps from 255 to 0. A pulse already in progress keeps its old length.
- R7: While rst_ni is low, all eight outputs are 0.
- R8: A selector change appears on the output one clock cycle after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psc0_i | input | 8 | Generator 0 prescale value |
| duty0_i | input | 8 | Generator 0 duty value |
| psc1_i | input | 8 | Generator 1 prescale value |
| duty1_i | input | 8 | Generator 1 duty value |
| sel_lo_i | input | 8 | Selector codes for LED0 to LED3 |
| sel_hi_i | input | 8 | Selector codes for LED4 to LED7 |
| led_oe_o | output | 8 | Output enables; 1 = pin pulled low (LED on) |

## Verification
The hardest case to reach is a duty change that arrives in the middle of a pulse, because it must not alter the pulse already in progress. The stimulus watches a generator-driven LED for its rising edge and writes a new duty value right then. It then checks that the current pulse keeps the old length and that the next full period uses the new one. To make full periods short enough to measure, the step divider is overridden to 2. Duty 0 and duty 255 are run to cover the two edges of the on/off compare.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  localparam int LED_N   = 8;
  localparam int GEN_N   = 2;
  localparam int CNT_W   = 8;
  localparam int STEPS   = 1 << CNT_W;
  localparam int BASE_HZ = 152;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_ON   = 2'b01,
    SRC_GEN0 = 2'b10,
    SRC_GEN1 = 2'b11
  } led_src_e;
endpackage

// File: rtl/blink_step_div.sv
module blink_step_div #(
  parameter int DIV = 1285
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign step_o = (cnt_q == LAST);

  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R1
endmodule

// File: rtl/blink_pwm_gen.sv
module blink_pwm_gen
  import led_blink_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] psc_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             on_o
);
  logic [CNT_W-1:0] psc_cnt_q, phase_q, psc_act_q, duty_act_q;
  logic adv, wrap;

  assign adv  = step_i && (psc_cnt_q == psc_act_q);
  assign wrap = adv && (phase_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_cnt_q  <= '0;
      phase_q    <= '0;
      psc_act_q  <= '0;
      duty_act_q <= '0;
    end else if (step_i) begin
      if (adv) begin
        psc_cnt_q <= '0;
        phase_q   <= phase_q + 1'b1;
        if (wrap) begin
          // shadow load only at the period boundary
          psc_act_q  <= psc_i;
          duty_act_q <= duty_i;
        end
      end else begin
        psc_cnt_q <= psc_cnt_q + 1'b1;
      end
    end
  end

  assign on_o = (phase_q < duty_act_q);

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> phase_q == $past(phase_q) + 1'b1); // R1
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv |=> $stable(phase_q)); // R1
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(duty_act_q) && $stable(psc_act_q)); // R6
  AST_ZERO_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_act_q == '0 |-> !on_o); // R2
endmodule

// File: rtl/led_src_mux.sv
module led_src_mux
  import led_blink_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic [GEN_N-1:0] gen_on_i,
  output logic             oe_o
);
  logic oe_d, oe_q;

  always_comb begin
    unique case (led_src_e'(sel_i))
      SRC_OFF:  oe_d = 1'b0;
      SRC_ON:   oe_d = 1'b1;
      SRC_GEN0: oe_d = gen_on_i[0];
      SRC_GEN1: oe_d = gen_on_i[1];
      default:  oe_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else oe_q <= oe_d;
  end

  assign oe_o = oe_q;

  AST_SRC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == SRC_OFF |=> !oe_o); // R3
  AST_SRC_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == SRC_ON |=> oe_o); // R3
  AST_SRC_GEN1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == SRC_GEN1 |=> oe_o == $past(gen_on_i[1])); // R4
endmodule

// File: rtl/led_blink_engine.sv
module led_blink_engine
  import led_blink_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int DIV_OVERRIDE = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] psc0_i,
  input  logic [7:0] duty0_i,
  input  logic [7:0] psc1_i,
  input  logic [7:0] duty1_i,
  input  logic [7:0] sel_lo_i,
  input  logic [7:0] sel_hi_i,
  output logic [7:0] led_oe_o
);
  localparam int AUTO_DIV = CLK_HZ / (BASE_HZ * STEPS);
  localparam int STEP_DIV = (DIV_OVERRIDE != 0) ? DIV_OVERRIDE :
                            ((AUTO_DIV < 1) ? 1 : AUTO_DIV);

  logic                 step;
  logic [CNT_W-1:0]     psc_a  [GEN_N];
  logic [CNT_W-1:0]     duty_a [GEN_N];
  logic [GEN_N-1:0]     gen_on;
  logic [2*LED_N-1:0]   sel_all;

  assign psc_a[0]  = psc0_i;
  assign psc_a[1]  = psc1_i;
  assign duty_a[0] = duty0_i;
  assign duty_a[1] = duty1_i;
  assign sel_all   = {sel_hi_i, sel_lo_i};

  blink_step_div #(.DIV(STEP_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_o (step)
  );

  for (genvar g = 0; g < GEN_N; g++) begin : g_gen
    blink_pwm_gen u_gen (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (step),
      .psc_i  (psc_a[g]),
      .duty_i (duty_a[g]),
      .on_o   (gen_on[g])
    );
  end

  for (genvar n = 0; n < LED_N; n++) begin : g_led
    led_src_mux u_mux (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (sel_all[2*n+1 -: 2]),
      .gen_on_i (gen_on),
      .oe_o     (led_oe_o[n])
    );
  end

  AST_RST_DARK: assert property (@(posedge clk_i)
    !rst_ni |-> led_oe_o == '0); // R7
endmodule

// File: tb/tb_led_blink_engine.sv
module tb_led_blink_engine;
  localparam int DIV = 2;

  typedef struct {
    int    led;
    int    exp_on;
    int    exp_per;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] psc0 = 8'd0, duty0 = 8'd0, psc1 = 8'd0, duty1 = 8'd0;
  logic [7:0] sel_lo = 8'h55, sel_hi = 8'h55;
  logic [7:0] oe;

  int checks = 0, fails = 0, done_cnt = 0;
  item_t q[$];
  bit finished = 0;

  always #2 clk = ~clk;

  led_blink_engine #(.DIV_OVERRIDE(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .psc0_i(psc0), .duty0_i(duty0), .psc1_i(psc1), .duty1_i(duty1),
    .sel_lo_i(sel_lo), .sel_hi_i(sel_hi), .led_oe_o(oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int per_of(input int psc);
    return 256 * (psc + 1) * DIV;
  endfunction

  task automatic push(input int led, input int psc, input int duty, input string tag);
    item_t it;
    it.led = led;
    it.exp_on = duty * (psc + 1) * DIV;
    it.exp_per = (duty == 0) ? 0 : per_of(psc);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // monitor: pop expected item, measure one period on the chosen LED
  initial begin
    forever begin
      item_t it;
      int on_c, tot, lim;
      bit prev, cur, seen;
      wait (q.size() > 0);
      it = q.pop_front();
      lim = 3 * per_of(3) + 20;
      seen = 0; on_c = 0; tot = 0;
      @(negedge clk); prev = oe[it.led];
      for (int i = 0; i < lim; i++) begin
        @(negedge clk); cur = oe[it.led];
        if (cur && !prev) begin seen = 1; prev = cur; break; end
        prev = cur;
      end
      if (seen) begin
        on_c = 1; tot = 1;
        for (int i = 0; i < lim; i++) begin
          @(negedge clk); cur = oe[it.led];
          if (cur && !prev) break;
          tot++;
          if (cur) on_c++;
          prev = cur;
        end
      end
      check(on_c == it.exp_on, {it.tag, " on-time"}, on_c, it.exp_on);
      check(tot == it.exp_per, {it.tag, " period"}, tot, it.exp_per);
      done_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, on_c;
    bit prev;
    // R7: selectors all request ON, reset must hold outputs dark
    repeat (3) @(negedge clk);
    check(oe == 8'h00, "R7 reset dark", oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 R5: LED0 off, LED1 on, LED2 gen0, LED3 gen1; LED4 gen0, LED5 on, LED6 off, LED7 gen1
    sel_lo = {2'b11, 2'b10, 2'b01, 2'b00};
    sel_hi = {2'b11, 2'b00, 2'b01, 2'b10};
    repeat (2) @(negedge clk);
    check(oe[0] == 1'b0, "R3 LED0 code 00 off", oe[0], 0);
    check(oe[1] == 1'b1, "R3 LED1 code 01 on", oe[1], 1);
    check(oe[5] == 1'b1, "R5 LED5 sel_hi[3:2] on", oe[5], 1);
    check(oe[6] == 1'b0, "R5 LED6 sel_hi[5:4] off", oe[6], 0);
    // R8: swap LED0/LED1 codes, visible one clock later
    sel_lo = {2'b11, 2'b10, 2'b00, 2'b01};
    @(negedge clk);
    check(oe[1:0] == 2'b01, "R8 one-cycle selector latency", oe[1:0], 1);

    // generator runs: new values land at the next wrap
    psc0 = 8'd0; duty0 = 8'd64; psc1 = 8'd2; duty1 = 8'd200;
    repeat (4000) @(negedge clk);
    n = done_cnt;
    push(2, 0, 64, "R1 R2 gen0 psc0 duty64");
    push(7, 2, 200, "R4 gen1 psc2 duty200");
    push(4, 0, 64, "R5 LED4 follows gen0");
    wait (done_cnt == n + 3);

    psc0 = 8'd1; duty0 = 8'd255; duty1 = 8'd0;
    repeat (4000) @(negedge clk);
    n = done_cnt;
    push(2, 1, 255, "R2 duty255 one step dark");
    push(7, 2, 0, "R2 duty0 never on");
    wait (done_cnt == n + 2);

    psc0 = 8'd0; duty0 = 8'd64;
    repeat (4000) @(negedge clk);
    // R6: change duty right after a rising edge, pulse keeps old length
    prev = oe[2];
    forever begin
      @(negedge clk);
      if (oe[2] && !prev) break;
      prev = oe[2];
    end
    duty0 = 8'd128;
    on_c = 1;
    forever begin
      @(negedge clk);
      if (!oe[2]) break;
      on_c++;
    end
    check(on_c == 64 * DIV, "R6 pulse in flight unchanged", on_c, 64 * DIV);
    n = done_cnt;
    push(2, 0, 128, "R6 new duty next period");
    wait (done_cnt == n + 1);
    finish_run();
  end
endmodule